// File: doc/BRIEF.md
# Packed SIMD Add/Subtract Unit

This block performs lane-wise addition and subtraction on a 32-bit word. Each operation chooses whether the word is treated as four 8-bit lanes or two 16-bit lanes. It also chooses one of three result treatments:

- wrap-around;
- halving, which gives the exact sum or difference divided by two and rounded toward minus infinity;
- saturation, which clamps the result to the lane range.

Each treatment comes in signed and unsigned form. With 16-bit lanes, two crossed forms are also available. In these, each halfword of the first operand meets the opposite halfword of the second operand: one halfword is added and the other is subtracted.

All variants share one segmented adder. Carries between byte segments are either passed on or cut, depending on the lane size. The adder produces one extra precision bit per lane, and that bit drives both halving and clamping.

Operations enter through a valid/ready input stream. Results leave through a valid/ready output stream that is held in a single result register. An operation is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the register is empty or is being emptied in the same cycle. Once `out_valid` is high, the result stays frozen until `out_ready` is seen high at a clock edge.

Top module: `simd_addsub`

## Requirements
- R1: `in_ready` is high whenever `out_valid` is low or `out_ready` is high. An operation accepted at a clock edge shows `out_valid` high after that edge, and `out_valid` falls after a transfer edge at which no new operation is accepted.
- R2: While `out_valid` is high and `out_ready` is low, `out_res` and `out_illegal` keep their values.
- R3: During and just after an active-low reset, `out_valid` is low and `in_ready` is high.
- R4: Lane size and wrap mode:
  - `in_half`=0 selects four 8-bit lanes at bits [8i+7:8i]; `in_half`=1 selects two 16-bit lanes at [15:0] and [31:16].
  - `in_op` = {kind[4:3], mode[2:1], signed[0]}.
  - kind 00 adds and kind 01 subtracts lane by lane.
  - Mode 00 wraps modulo the lane size, with no carry or borrow between lanes.
- R5: Mode 01 (halving) returns floor((a±b)/2), computed exactly. Operands are treated as two's complement when signed=1 and as unsigned when signed=0.
- R6: Mode 10 with signed=1 clamps each lane result to the range -2^(w-1) to 2^(w-1)-1.
- R7: Mode 10 with signed=0 clamps each lane result to the range 0 to 2^w-1.
- R8: Kind 10 (cross add-sub, 16-bit lanes) gives hi = a[31:16]+b[15:0] and lo = a[15:0]-b[31:16]. The mode and signed fields apply to each lane as in R4 to R7.
- R9: Kind 11 (cross sub-add, 16-bit lanes) gives hi = a[31:16]-b[15:0] and lo = a[15:0]+b[31:16]. The mode and signed fields apply as in R4 to R7.
- R10: An operation is illegal if it uses a crossed kind with 8-bit lanes or uses mode 11. An illegal operation yields `out_illegal`=1 and `out_res`=0. Every other operation yields `out_illegal`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An operation is offered |
| in_ready | output | 1 | The unit can take the offered operation |
| in_a | input | 32 | First packed operand |
| in_b | input | 32 | Second packed operand |
| in_half | input | 1 | Lane size: 0 = four bytes, 1 = two halfwords |
| in_op | input | 5 | Operation code {kind, mode, signed} |
| out_valid | output | 1 | A result is held |
| out_ready | input | 1 | The consumer takes the held result |
| out_res | output | 32 | Packed result |
| out_illegal | output | 1 | The held result came from an illegal operation |

## Verification
Two events can fall on the same clock edge: the held result drains to the consumer while a new operation is captured. The unit is designed so that the capture never overwrites a result that has not been taken. The bench provokes this by keeping `in_valid` high back to back while `out_ready` toggles at random. A scoreboard then confirms that every expected result arrives exactly once and in order. Over any stall, the bench also confirms that the held result and its illegal flag stay unchanged until they are taken.

// File: rtl/simd_pkg.sv
package simd_pkg;

  typedef enum logic [1:0] {
    K_ADD = 2'b00,
    K_SUB = 2'b01,
    K_XAS = 2'b10,
    K_XSA = 2'b11
  } kind_e;

  typedef enum logic [1:0] {
    M_WRAP = 2'b00,
    M_HALF = 2'b01,
    M_SAT  = 2'b10,
    M_RSVD = 2'b11
  } mode_e;

  typedef struct packed {
    kind_e kind;
    mode_e mode;
    logic  sgn;
  } op_t;

endpackage

// File: rtl/simd_seg_adder.sv
// Segmented adder: each segment either starts a lane or continues the carry
// of the segment below; ext gives the lane's extra precision bit at that segment.
module simd_seg_adder #(
  parameter int SEG_W = 8,
  parameter int NSEG  = 4
) (
  input  logic [NSEG*SEG_W-1:0] a,
  input  logic [NSEG*SEG_W-1:0] b,
  input  logic [NSEG-1:0]       sub,
  input  logic [NSEG-2:0]       chain,
  input  logic                  sgn,
  output logic [NSEG*SEG_W-1:0] sum,
  output logic [NSEG-1:0]       ext
);

  logic [NSEG-1:0] carry;

  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    logic             cin;
    logic [SEG_W-1:0] as, bs, bx;
    logic [SEG_W:0]   t;

    assign as = a[g*SEG_W +: SEG_W];
    assign bs = b[g*SEG_W +: SEG_W];
    assign bx = bs ^ {SEG_W{sub[g]}};

    if (g == 0) begin : g_first
      assign cin = sub[g];
    end else begin : g_rest
      assign cin = chain[g-1] ? carry[g-1] : sub[g];
    end

    assign t = {1'b0, as} + {1'b0, bx} + {{SEG_W{1'b0}}, cin};
    assign sum[g*SEG_W +: SEG_W] = t[SEG_W-1:0];
    assign carry[g] = t[SEG_W];
    assign ext[g] = (sgn & as[SEG_W-1]) ^ ((sgn & bs[SEG_W-1]) ^ sub[g]) ^ carry[g];
  end

endmodule

// File: rtl/simd_lane_post.sv
// Turns a (W+1)-bit exact lane result into the W-bit wrapped, halved or clamped value.
module simd_lane_post
  import simd_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W:0]   raw,
  input  mode_e        mode,
  input  logic         sgn,
  input  logic         sub,
  output logic [W-1:0] res
);

  localparam logic [W-1:0] S_MAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] S_MIN = {1'b1, {(W-1){1'b0}}};

  always_comb begin
    unique case (mode)
      M_WRAP: res = raw[W-1:0];
      M_HALF: res = raw[W:1];
      M_SAT: begin
        if (sgn) begin
          if (raw[W] != raw[W-1]) res = raw[W] ? S_MIN : S_MAX;
          else                    res = raw[W-1:0];
        end else begin
          if (raw[W]) res = sub ? '0 : '1;
          else        res = raw[W-1:0];
        end
      end
      default: res = '0;
    endcase
  end

endmodule

// File: rtl/simd_addsub.sv
module simd_addsub
  import simd_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int SEG_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_a,
  input  logic [WORD_W-1:0] in_b,
  input  logic              in_half,
  input  logic [4:0]        in_op,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_res,
  output logic              out_illegal
);

  localparam int NSEG   = WORD_W / SEG_W;
  localparam int HALF_W = WORD_W / 2;
  localparam int NHSEG  = NSEG / 2;

  op_t op;
  assign op = op_t'(in_op);

  logic is_cross, sub_hi, sub_lo, illegal;
  assign is_cross = op.kind[1];
  assign sub_hi   = (op.kind == K_SUB) || (op.kind == K_XSA);
  assign sub_lo   = (op.kind == K_SUB) || (op.kind == K_XAS);
  assign illegal  = (op.mode == M_RSVD) || (is_cross && !in_half);

  // Crossed forms pair each halfword of a with the opposite halfword of b.
  logic [WORD_W-1:0] b_eff;
  assign b_eff = is_cross ? {in_b[HALF_W-1:0], in_b[WORD_W-1:HALF_W]} : in_b;

  logic [NSEG-1:0] seg_sub;
  logic [NSEG-2:0] chain;

  always_comb begin
    for (int g = 0; g < NSEG; g++) begin
      if (in_half) seg_sub[g] = (g >= NHSEG) ? sub_hi : sub_lo;
      else         seg_sub[g] = (op.kind == K_SUB);
    end
    for (int g = 0; g < NSEG - 1; g++) begin
      chain[g] = in_half && (((g + 1) % NHSEG) != 0);
    end
  end

  logic [WORD_W-1:0] sum;
  logic [NSEG-1:0]   ext;

  simd_seg_adder #(.SEG_W(SEG_W), .NSEG(NSEG)) u_adder (
    .a     (in_a),
    .b     (b_eff),
    .sub   (seg_sub),
    .chain (chain),
    .sgn   (op.sgn),
    .sum   (sum),
    .ext   (ext)
  );

  logic [WORD_W-1:0] byte_res, half_res;

  for (genvar g = 0; g < NSEG; g++) begin : g_byte
    simd_lane_post #(.W(SEG_W)) u_post (
      .raw  ({ext[g], sum[g*SEG_W +: SEG_W]}),
      .mode (op.mode),
      .sgn  (op.sgn),
      .sub  (seg_sub[g]),
      .res  (byte_res[g*SEG_W +: SEG_W])
    );
  end

  for (genvar h = 0; h < 2; h++) begin : g_half
    simd_lane_post #(.W(HALF_W)) u_post (
      .raw  ({ext[(h+1)*NHSEG-1], sum[h*HALF_W +: HALF_W]}),
      .mode (op.mode),
      .sgn  (op.sgn),
      .sub  (seg_sub[h*NHSEG]),
      .res  (half_res[h*HALF_W +: HALF_W])
    );
  end

  logic [WORD_W-1:0] res_next;
  assign res_next = illegal ? '0 : (in_half ? half_res : byte_res);

  logic take;
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_res     <= '0;
      out_illegal <= 1'b0;
    end else if (take) begin
      out_valid   <= 1'b1;
      out_res     <= res_next;
      out_illegal <= illegal;
    end else if (out_ready) begin
      out_valid   <= 1'b0;
    end
  end

endmodule

// File: rtl/simd_addsub_chk.sv
module simd_addsub_chk #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              in_half,
  input logic [4:0]        in_op,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_res,
  input logic              out_illegal
);

  p_reset_idle_r3: assert property (@(posedge clk) !rst_n |-> !out_valid);

  p_ready_free_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  p_accept_shows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  p_drain_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid);

  p_stall_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_res) && $stable(out_illegal)));

  p_illegal_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_illegal) |-> (out_res == '0));

  p_byte_cross_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_op[4] && !in_half) |=> out_illegal);

  p_rsvd_mode_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && (in_op[2:1] == 2'b11)) |=> out_illegal);

endmodule

bind simd_addsub simd_addsub_chk #(.WORD_W(WORD_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_half     (in_half),
  .in_op       (in_op),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_res     (out_res),
  .out_illegal (out_illegal)
);

// File: tb/simd_addsub_test.sv
module simd_addsub_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_a = '0;
  logic [31:0] in_b = '0;
  logic        in_half = 1'b0;
  logic [4:0]  in_op = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_res;
  logic        out_illegal;

  int checks = 0;
  int fails = 0;
  bit stall_mode = 0;
  bit finished = 0;

  logic [31:0] res_q[$];
  logic        ill_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  simd_addsub uut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_half(in_half), .in_op(in_op),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_res(out_res), .out_illegal(out_illegal)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] mk(input int kind, input int mode, input int sgn);
    return {kind[1:0], mode[1:0], sgn[0]};
  endfunction

  function automatic longint field(input logic [31:0] x, input int off, input int w, input bit sgn);
    longint v;
    v = longint'((x >> off)) & ((longint'(1) << w) - 1);
    if (sgn && v[w-1]) v = v - (longint'(1) << w);
    return v;
  endfunction

  // Reference model built from the requirement text.
  function automatic logic [32:0] model(input logic [31:0] a, input logic [31:0] b,
                                        input logic half, input logic [4:0] op);
    int kind, mode, w, n;
    bit sgn;
    logic [31:0] res;
    kind = int'(op[4:3]);
    mode = int'(op[2:1]);
    sgn  = op[0];
    if (mode == 3 || (kind >= 2 && !half)) return {1'b1, 32'h0};
    w = half ? 16 : 8;
    n = 32 / w;
    res = '0;
    for (int i = 0; i < n; i++) begin
      int off, boff;
      bit subl;
      longint va, vb, v, r, lo, hi;
      off  = i * w;
      boff = (kind >= 2) ? ((i == 1) ? 0 : 16) : off;
      subl = (kind == 1) || (kind == 2 && i == 0) || (kind == 3 && i == 1);
      va = field(a, off, w, sgn);
      vb = field(b, boff, w, sgn);
      v = subl ? va - vb : va + vb;
      if (sgn) begin lo = -(longint'(1) << (w-1)); hi = (longint'(1) << (w-1)) - 1; end
      else     begin lo = 0; hi = (longint'(1) << w) - 1; end
      case (mode)
        0: r = v;
        1: r = v >>> 1;
        default: r = (v < lo) ? lo : ((v > hi) ? hi : v);
      endcase
      r = r & ((longint'(1) << w) - 1);
      res = res | (32'(r) << off);
    end
    return {1'b0, res};
  endfunction

  function automatic string tag_of(input logic half, input logic [4:0] op);
    if (op[2:1] == 2'b11 || (op[4] && !half)) return "R10";
    if (op[4:3] == 2'b10) return "R8";
    if (op[4:3] == 2'b11) return "R9";
    if (op[2:1] == 2'b01) return "R5";
    if (op[2:1] == 2'b10) return op[0] ? "R6" : "R7";
    return "R4";
  endfunction

  // Driver: called at a falling edge; returns at a falling edge after acceptance.
  task automatic send(input logic [31:0] a, input logic [31:0] b, input logic half, input logic [4:0] op);
    logic [32:0] e;
    bit done;
    in_a = a; in_b = b; in_half = half; in_op = op; in_valid = 1'b1;
    e = model(a, b, half, op);
    done = 0;
    while (!done) begin
      #(CLK_PERIOD/4);
      if (in_ready) begin
        res_q.push_back(e[31:0]);
        ill_q.push_back(e[32]);
        tag_q.push_back(tag_of(half, op));
        done = 1;
      end
      @(negedge clk);
    end
  endtask

  // Consumer back-pressure.
  initial begin
    forever begin
      @(negedge clk);
      out_ready = stall_mode ? (($urandom % 3) != 0) : 1'b1;
    end
  end

  // Monitor and scoreboard.
  initial begin
    bit          prev_fire = 0;
    bit          held = 0;
    logic [31:0] held_res = '0;
    logic        held_ill = 1'b0;
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/4);
      if (rst_n) begin
        if (prev_fire) check(out_valid === 1'b1, "R1 valid after accept", 32'(out_valid), 32'd1);
        if (!out_valid) check(in_ready === 1'b1, "R1 ready when empty", 32'(in_ready), 32'd1);
        if (held) begin
          check(out_res === held_res, "R2 result held", out_res, held_res);
          check(out_illegal === held_ill, "R2 flag held", 32'(out_illegal), 32'(held_ill));
        end
        if (out_valid && out_ready) begin
          if (res_q.size() == 0) begin
            check(1'b0, "R1 unexpected result", out_res, 32'h0);
          end else begin
            logic [31:0] er;
            logic        ei;
            string       t;
            er = res_q.pop_front();
            ei = ill_q.pop_front();
            t  = tag_q.pop_front();
            check(out_res === er, {t, " result"}, out_res, er);
            check(out_illegal === ei, {t, " illegal flag"}, 32'(out_illegal), 32'(ei));
          end
        end
        prev_fire = in_valid && in_ready;
        held      = out_valid && !out_ready;
        held_res  = out_res;
        held_ill  = out_illegal;
      end
    end
  end

  // Watchdog.
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #(CLK_PERIOD/4);
    check(out_valid === 1'b0, "R3 out_valid in reset", 32'(out_valid), 32'd0);
    check(in_ready === 1'b1, "R3 in_ready in reset", 32'(in_ready), 32'd1);
    @(negedge clk);
    rst_n = 1'b1;
    #(CLK_PERIOD/4);
    check(out_valid === 1'b0, "R3 out_valid after reset", 32'(out_valid), 32'd0);
    @(negedge clk);

    // R4 wrap, no carry between lanes
    send(32'h01FF7F80, 32'h01010180, 1'b0, mk(0, 0, 0));
    send(32'h00FFFFFF, 32'h00010001, 1'b1, mk(0, 0, 0));
    send(32'h00010203, 32'h01010101, 1'b0, mk(1, 0, 0));
    send(32'h00000000, 32'h00010001, 1'b1, mk(1, 0, 1));
    // R5 halving
    send(32'h80FF7FFF, 32'hFF01017F, 1'b0, mk(0, 1, 1));
    send(32'hFFFF8000, 32'hFFFF8000, 1'b1, mk(0, 1, 0));
    send(32'h00008000, 32'h00017FFF, 1'b1, mk(1, 1, 1));
    send(32'h00000001, 32'h01000002, 1'b0, mk(1, 1, 0));
    // R6 signed saturation
    send(32'h7F80017F, 32'h01FF0101, 1'b0, mk(0, 2, 1));
    send(32'h80007FFF, 32'h00010001, 1'b1, mk(1, 2, 1));
    send(32'h7FFF8000, 32'h7FFF8000, 1'b1, mk(0, 2, 1));
    // R7 unsigned saturation
    send(32'hFF0080FE, 32'h01010101, 1'b0, mk(0, 2, 0));
    send(32'h00000005, 32'h01000009, 1'b0, mk(1, 2, 0));
    send(32'hFFFF0001, 32'h00010002, 1'b1, mk(0, 2, 0));
    send(32'h0001FFFF, 32'h0002FFFF, 1'b1, mk(1, 2, 0));
    // R8 cross add-sub
    send(32'h12345678, 32'h11112222, 1'b1, mk(2, 0, 0));
    send(32'h7FFF8000, 32'h00010001, 1'b1, mk(2, 2, 1));
    send(32'hFFFF0000, 32'h00010001, 1'b1, mk(2, 2, 0));
    send(32'h80000001, 32'h0003FFFF, 1'b1, mk(2, 1, 1));
    // R9 cross sub-add
    send(32'h12345678, 32'h11112222, 1'b1, mk(3, 0, 0));
    send(32'h80007FFF, 32'h00010001, 1'b1, mk(3, 2, 1));
    send(32'h0000FFFF, 32'h00010001, 1'b1, mk(3, 2, 0));
    send(32'h0001FFFF, 32'hFFFF0003, 1'b1, mk(3, 1, 0));
    // R10 illegal
    send(32'h12345678, 32'h9ABCDEF0, 1'b0, mk(2, 0, 0));
    send(32'h12345678, 32'h9ABCDEF0, 1'b0, mk(3, 2, 1));
    send(32'h12345678, 32'h9ABCDEF0, 1'b1, mk(0, 3, 0));
    send(32'h12345678, 32'h9ABCDEF0, 1'b0, mk(1, 3, 1));

    // Mixed traffic under random back-pressure (R1, R2 and all lane functions)
    stall_mode = 1;
    for (int i = 0; i < 400; i++) begin
      send($urandom, $urandom, 1'($urandom % 2), 5'($urandom % 32));
    end
    in_valid = 1'b0;
    stall_mode = 0;

    for (int i = 0; i < 50 && res_q.size() != 0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    check(res_q.size() == 0, "R1 all results drained", 32'(res_q.size()), 32'd0);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule